// File: doc/BRIEF.md
# Nine-bit multidrop address filter

This block sits between a UART receive deserializer and the receive FIFO. On a multidrop bus every character carries a ninth bit. A ninth bit of 1 marks a station address and a ninth bit of 0 marks payload. For each received character the filter decides whether to drop it or forward it to the FIFO, which status bit to attach, and whether to raise the line-status interrupt.

There are two multidrop modes:

- **Normal mode.** Every address byte is reported to software, and software gates payload through a receiver-enable bit.
- **Automatic mode.** Each address byte is compared with a programmed station address. On a match the filter enables its own receiver. On a mismatch it disables the receiver, so only the payload that follows a matching address reaches the FIFO.

With multidrop turned off, the filter forwards every character unchanged and reports the deserializer's parity-error flag.

Top module: `mdrop_addr_filter`

## Requirements
- R1: After reset `push_valid` and `lsr_irq` are 0 and the automatic-mode receiver enable is cleared, so in automatic mode a payload byte (ninth bit 0) that arrives before any matching address is dropped.
- R2: With `md_en` = 0 every received character is pushed, `push_data` equals `rx_data` and `push_flag` equals `rx_par_err`. `lsr_irq` is set when `rx_par_err` is 1.
- R3: In normal mode (`md_en` = 1, `auto_mode` = 0) a character with ninth bit 1 is always pushed with `push_flag` = 1 and sets `lsr_irq`, whatever the value of `sw_rx_en`.
- R4: In normal mode a character with ninth bit 0 is pushed with `push_flag` = 0 when `sw_rx_en` = 1 and is dropped when `sw_rx_en` = 0. Such a character never sets `lsr_irq`.
- R5: In automatic mode (`md_en` = 1, `auto_mode` = 1) a character with ninth bit 1 and `rx_data` equal to `slave_addr` is pushed with `push_flag` holding its ninth bit (1). It sets `lsr_irq` and enables the receiver.
- R6: In automatic mode, while the receiver is enabled, a character with ninth bit 0 is pushed with `push_flag` = 0 and does not set `lsr_irq`.
- R7: In automatic mode a character with ninth bit 1 whose `rx_data` differs from `slave_addr` is not pushed and does not set `lsr_irq`. It disables the receiver, so following payload is dropped until the next matching address.
- R8: `lsr_irq` stays 1 until a cycle with `irq_ack` = 1 clears it. If a new interrupt event coincides with `irq_ack`, the flag stays set.
- R9: A forwarded character appears on `push_valid`/`push_data`/`push_flag` exactly one clock after the cycle in which `rx_valid` was 1. No push occurs without a preceding `rx_valid`.
- R10: Any cycle in which automatic mode is not selected clears the automatic receiver enable. On returning to automatic mode, a matching address is needed again before payload is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rx_valid | input | 1 | One-cycle strobe: a character is available |
| rx_data | input | DATA_W | Received character, low bits |
| rx_bit9 | input | 1 | Ninth bit of the character (1 = address) |
| rx_par_err | input | 1 | Parity error from the deserializer, used when multidrop is off |
| md_en | input | 1 | Multidrop operation enable |
| auto_mode | input | 1 | 0 = normal multidrop mode, 1 = automatic address mode |
| slave_addr | input | DATA_W | Station address compared in automatic mode |
| sw_rx_en | input | 1 | Software receiver enable for normal mode |
| irq_ack | input | 1 | Clears the line-status interrupt |
| push_valid | output | 1 | FIFO write strobe |
| push_data | output | DATA_W | Character written to the FIFO |
| push_flag | output | 1 | Status bit written beside the character (parity error or ninth bit) |
| lsr_irq | output | 1 | Sticky line-status interrupt |

## Verification
The bench builds the filter with the default eight-bit character width and programs the station address 0x5A. This makes it possible to send addresses that differ from the station address in one bit only, such as 0x5B, and to check that they are rejected. Payload values equal to the station address are sent with the ninth bit cleared, which shows that the ninth bit, not the value, decides the address path. Mode switches between payload bytes show that leaving automatic mode clears the self-enable. Acknowledges are timed to coincide with new interrupt events, to check that a new event keeps the flag set.

// File: rtl/mdrop_pkg.sv
// Shared types for the multidrop address filter.
// Assumes: one character is classified per rx_valid strobe.
package mdrop_pkg;

    // Per-character decision produced by the classifier
    typedef struct packed {
        logic push;    // write the character into the FIFO
        logic flag;    // status bit stored beside the character
        logic irq;     // raise the line-status interrupt
        logic en_set;  // automatic mode: enable receiver
        logic en_clr;  // automatic mode: disable receiver
    } md_dec_t;

endpackage

// File: rtl/mdrop_classify.sv
// Combinational classifier: decides drop/forward/self-enable for one character.
// Assumes: auto_en is the registered automatic-mode receiver enable.
module mdrop_classify
    import mdrop_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              rx_valid,
    input  logic [DATA_W-1:0] rx_data,
    input  logic              rx_bit9,
    input  logic              rx_par_err,
    input  logic              md_en,
    input  logic              auto_mode,
    input  logic [DATA_W-1:0] slave_addr,
    input  logic              sw_rx_en,
    input  logic              auto_en,
    output md_dec_t           dec
);

    logic addr_hit;

    // Compare the character against the programmed station address
    assign addr_hit = (rx_data == slave_addr);

    // Build the decision for the current character
    always_comb begin
        dec = '0;
        if (rx_valid) begin
            if (!md_en) begin
                dec.push = 1'b1;
                dec.flag = rx_par_err;
                dec.irq  = rx_par_err;
            end else if (!auto_mode) begin
                if (rx_bit9) begin
                    dec.push = 1'b1;
                    dec.flag = 1'b1;
                    dec.irq  = 1'b1;
                end else begin
                    dec.push = sw_rx_en;
                end
            end else begin
                if (rx_bit9) begin
                    if (addr_hit) begin
                        dec.push   = 1'b1;
                        dec.flag   = rx_bit9;
                        dec.irq    = 1'b1;
                        dec.en_set = 1'b1;
                    end else begin
                        dec.en_clr = 1'b1;
                    end
                end else begin
                    dec.push = auto_en;
                    dec.flag = rx_bit9;
                end
            end
        end
    end

endmodule

// File: rtl/mdrop_enable_state.sv
// Holds the automatic-mode receiver enable.
// Assumes: set and clear never occur together (classifier guarantees it).
module mdrop_enable_state (
    input  logic clk,
    input  logic rst_n,
    input  logic auto_sel,
    input  logic en_set,
    input  logic en_clr,
    output logic auto_en
);

    // Track enable; cleared whenever automatic mode is not selected
    always_ff @(posedge clk) begin
        if (!rst_n)        auto_en <= 1'b0;
        else if (!auto_sel) auto_en <= 1'b0;
        else if (en_set)   auto_en <= 1'b1;
        else if (en_clr)   auto_en <= 1'b0;
    end

endmodule

// File: rtl/mdrop_out_stage.sv
// Registers the FIFO push and keeps the sticky line-status interrupt.
// Assumes: irq set has priority over acknowledge.
module mdrop_out_stage
    import mdrop_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  md_dec_t           dec,
    input  logic [DATA_W-1:0] rx_data,
    input  logic              irq_ack,
    output logic              push_valid,
    output logic [DATA_W-1:0] push_data,
    output logic              push_flag,
    output logic              lsr_irq
);

    // Register the push strobe and the pushed character
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            push_valid <= 1'b0;
            push_data  <= '0;
            push_flag  <= 1'b0;
        end else begin
            push_valid <= dec.push;
            if (dec.push) begin
                push_data <= rx_data;
                push_flag <= dec.flag;
            end
        end
    end

    // Sticky interrupt: set by an event, cleared by acknowledge
    always_ff @(posedge clk) begin
        if (!rst_n)       lsr_irq <= 1'b0;
        else if (dec.irq) lsr_irq <= 1'b1;
        else if (irq_ack) lsr_irq <= 1'b0;
    end

endmodule

// File: rtl/mdrop_addr_filter.sv
// Top: nine-bit multidrop address filter between deserializer and receive FIFO.
// Assumes: inputs are synchronous to clk; one-cycle push latency.
module mdrop_addr_filter
    import mdrop_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_valid,
    input  logic [DATA_W-1:0] rx_data,
    input  logic              rx_bit9,
    input  logic              rx_par_err,
    input  logic              md_en,
    input  logic              auto_mode,
    input  logic [DATA_W-1:0] slave_addr,
    input  logic              sw_rx_en,
    input  logic              irq_ack,
    output logic              push_valid,
    output logic [DATA_W-1:0] push_data,
    output logic              push_flag,
    output logic              lsr_irq
);

    md_dec_t dec;
    logic    auto_en;
    logic    auto_sel;

    // Automatic mode is active only inside multidrop operation
    assign auto_sel = md_en & auto_mode;

    mdrop_classify #(.DATA_W(DATA_W)) u_classify (
        .rx_valid   (rx_valid),
        .rx_data    (rx_data),
        .rx_bit9    (rx_bit9),
        .rx_par_err (rx_par_err),
        .md_en      (md_en),
        .auto_mode  (auto_mode),
        .slave_addr (slave_addr),
        .sw_rx_en   (sw_rx_en),
        .auto_en    (auto_en),
        .dec        (dec)
    );

    mdrop_enable_state u_enable (
        .clk      (clk),
        .rst_n    (rst_n),
        .auto_sel (auto_sel),
        .en_set   (dec.en_set),
        .en_clr   (dec.en_clr),
        .auto_en  (auto_en)
    );

    mdrop_out_stage #(.DATA_W(DATA_W)) u_out (
        .clk        (clk),
        .rst_n      (rst_n),
        .dec        (dec),
        .rx_data    (rx_data),
        .irq_ack    (irq_ack),
        .push_valid (push_valid),
        .push_data  (push_data),
        .push_flag  (push_flag),
        .lsr_irq    (lsr_irq)
    );

endmodule

// File: rtl/mdrop_addr_filter_chk.sv
// Port-level properties of the multidrop filter, bound to the top module.
module mdrop_addr_filter_chk #(
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              rx_valid,
    input logic [DATA_W-1:0] rx_data,
    input logic              rx_bit9,
    input logic              rx_par_err,
    input logic              md_en,
    input logic              auto_mode,
    input logic [DATA_W-1:0] slave_addr,
    input logic              sw_rx_en,
    input logic              irq_ack,
    input logic              push_valid,
    input logic [DATA_W-1:0] push_data,
    input logic              push_flag,
    input logic              lsr_irq
);

    a_r9_push_needs_valid: assert property (@(posedge clk) disable iff (!rst_n)
        push_valid |-> $past(rx_valid));

    a_r2_passthrough: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && !md_en) |=> (push_valid && push_data == $past(rx_data)
                                  && push_flag == $past(rx_par_err)));

    a_r3_normal_addr_reported: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && md_en && !auto_mode && rx_bit9) |=> (push_valid && push_flag && lsr_irq));

    a_r4_normal_data_gated: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && md_en && !auto_mode && !rx_bit9 && !sw_rx_en) |=> !push_valid);

    a_r5_auto_match_pushed: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && md_en && auto_mode && rx_bit9 && rx_data == slave_addr)
            |=> (push_valid && push_flag && lsr_irq));

    a_r7_auto_mismatch_dropped: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && md_en && auto_mode && rx_bit9 && rx_data != slave_addr)
            |=> !push_valid);

    a_r8_irq_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (lsr_irq && !irq_ack) |=> lsr_irq);

endmodule

bind mdrop_addr_filter mdrop_addr_filter_chk #(.DATA_W(DATA_W)) u_chk (.*);

// File: tb/mdrop_addr_filter_bench.sv
// Scoreboard bench for the multidrop address filter.
module mdrop_addr_filter_bench;

    localparam int DW = 8;
    localparam logic [DW-1:0] ADDR = 8'h5A;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          rx_valid = 1'b0;
    logic [DW-1:0] rx_data = '0;
    logic          rx_bit9 = 1'b0;
    logic          rx_par_err = 1'b0;
    logic          md_en = 1'b0;
    logic          auto_mode = 1'b0;
    logic [DW-1:0] slave_addr = ADDR;
    logic          sw_rx_en = 1'b0;
    logic          irq_ack = 1'b0;
    logic          push_valid;
    logic [DW-1:0] push_data;
    logic          push_flag;
    logic          lsr_irq;

    int checks = 0;
    int errors = 0;
    logic [DW:0] exp_q[$];   // {flag, data}
    logic        m_en  = 1'b0;
    logic        m_irq = 1'b0;
    bit          done  = 1'b0;

    always #2 clk = ~clk;

    mdrop_addr_filter #(.DATA_W(DW)) u_mdrop_addr_filter (.*);

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Driver: predicts from the requirements, then presents one character
    task automatic send(input string req, input logic [DW-1:0] d, input logic b9, input logic pe);
        if (!md_en) begin
            exp_q.push_back({pe, d}); if (pe) m_irq = 1'b1;          // R2
        end else if (!auto_mode) begin
            if (b9) begin exp_q.push_back({1'b1, d}); m_irq = 1'b1; end // R3
            else if (sw_rx_en) exp_q.push_back({1'b0, d});             // R4
        end else begin
            if (b9) begin
                if (d == ADDR) begin m_en = 1'b1; exp_q.push_back({1'b1, d}); m_irq = 1'b1; end // R5
                else m_en = 1'b0;                                                          // R7
            end else if (m_en) exp_q.push_back({1'b0, d});                                 // R6
        end
        rx_valid = 1'b1; rx_data = d; rx_bit9 = b9; rx_par_err = pe;
        @(negedge clk);
        rx_valid = 1'b0; rx_bit9 = 1'b0; rx_par_err = 1'b0;
        check({req, " irq"}, {31'd0, lsr_irq}, {31'd0, m_irq});
    endtask

    task automatic set_mode(input logic md, input logic au, input logic sw);
        md_en = md; auto_mode = au; sw_rx_en = sw;
        @(negedge clk);
        if (!(md && au)) m_en = 1'b0;   // R10
    endtask

    task automatic ack(input string req);
        irq_ack = 1'b1;
        @(negedge clk);
        irq_ack = 1'b0;
        m_irq = 1'b0;
        check(req, {31'd0, lsr_irq}, 32'd0);
    endtask

    // Monitor: every push must match the head of the queue (R9 timing)
    always @(negedge clk) begin
        if (rst_n && push_valid) begin
            if (exp_q.size() == 0) check("R9 unexpected push", {23'd0, push_flag, push_data}, 32'h1FF);
            else begin
                logic [DW:0] e;
                e = exp_q.pop_front();
                check("R9 push", {23'd0, push_flag, push_data}, {23'd0, e});
            end
        end
    end

    initial begin
        #200000;
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog expired");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 push idle", {31'd0, push_valid}, 32'd0);
        check("R1 irq idle", {31'd0, lsr_irq}, 32'd0);
        // R1: automatic mode straight after reset drops payload
        set_mode(1, 1, 0);
        send("R1", 8'h11, 0, 0);
        send("R1", ADDR, 0, 0);      // value equals address but ninth bit 0
        // R5/R6
        send("R5", ADDR, 1, 0);
        send("R6", 8'h22, 0, 0);
        ack("R8 ack");
        send("R6", 8'h33, 0, 0);
        // R7: near-miss address disables
        send("R7", 8'h5B, 1, 0);
        send("R7", 8'h44, 0, 0);
        send("R7", 8'h55, 0, 0);
        send("R5", ADDR, 1, 0);
        send("R6", 8'h66, 0, 0);
        // R10: leaving automatic mode clears the enable
        set_mode(1, 0, 0);
        set_mode(1, 1, 0);
        send("R10", 8'h77, 0, 0);
        ack("R8 ack");
        // R3/R4 normal mode
        set_mode(1, 0, 0);
        send("R4", 8'h01, 0, 0);
        send("R3", 8'h02, 1, 0);
        ack("R8 ack");
        set_mode(1, 0, 1);
        send("R4", 8'h03, 0, 0);
        send("R3", 8'h04, 1, 0);
        // R8: event coinciding with acknowledge keeps flag set
        irq_ack = 1'b1;
        send("R8 set wins", 8'h05, 1, 0);
        irq_ack = 1'b0;
        ack("R8 ack");
        // R2 multidrop off
        set_mode(0, 1, 0);
        send("R2", 8'hA5, 1, 0);
        send("R2", 8'h3C, 0, 1);
        send("R2", 8'hC3, 0, 0);
        repeat (2) @(negedge clk);
        check("R9 queue drained", exp_q.size(), 32'd0);
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule